// File: doc/BRIEF.md
# Serial-to-Parallel Word Demultiplexer with Bit Slip and Byte Parity

This block sits behind a clock-and-data recovery front end. It takes a retimed serial stream, one bit per bit-clock cycle, and packs it into a 32-bit parallel word. Each byte of that word gets a parity bit. The word and its parity are loaded into an output register once per word period. A divided word clock, `word_clk`, falls on the same bit-clock edge that loads the register, so downstream logic can capture the data on the rising edge of `word_clk` or later.

A 2-bit mode input selects one of the following:
- full-width operation (32 bits per word),
- half-width operation (16 bits per word),
- a forced all-ones output,
- a reserved code that holds the outputs at zero.

Two further controls are available. One complements every incoming bit. The other picks odd or even parity. An active-low slip strobe causes exactly one incoming bit to be skipped. External framing logic uses this to move the word boundary one bit at a time until bytes line up.

Top module: `serdemux_top`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, `word_out` and `par_out` become zero and `word_clk` becomes one. The first bit captured after reset lands in `word_out[31]`.
- R2: In full mode (`mode`=2'b10), bits fill `word_out` from bit 31 down to bit 0 in arrival order. Bits 31:24 form byte 1, the most significant byte. The register loads on the edge that captures the 32nd bit.
- R3: `par_out[3]` covers bits 31:24, `par_out[2]` covers bits 23:16, `par_out[1]` covers bits 15:8 and `par_out[0]` covers bits 7:0. With `odd_par`=0, each parity bit makes the count of ones in its byte plus itself even. Each parity bit is presented with its own byte.
- R4: With `odd_par`=1, each parity bit makes the count of ones in its byte plus itself odd.
- R5: With `invert`=1, every serial bit is complemented before it is packed.
- R6: The slip works as follows.
  - When `slip_n` falls, the bit presented at the third rising edge of `clk` after the fall is discarded. It is not packed and it does not advance the word position.
  - A low level held for any length of time drops only one bit.
  - A rise of `slip_n` drops nothing.
- R7: In half mode (`mode`=2'b01), 16 bits form a word in `word_out[31:16]`, with the first bit in bit 31. `word_out[15:0]` and `par_out[1:0]` are zero. The register loads every 16 bits.
- R8: With `mode`=2'b11, every load sets `word_out` and `par_out` to all ones. The word period is 32 bits.
- R9: With `mode`=2'b00 (reserved), every load sets `word_out` and `par_out` to zero. The word period is 32 bits.
- R10: `word_out` and `par_out` change only on the loading edge. `word_clk` falls on that edge and rises on the edge that captures the middle bit of the word (bit 16 of 32, bit 8 of 16).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one serial bit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Retimed serial data |
| invert | input | 1 | 1 complements incoming bits |
| odd_par | input | 1 | 0 even parity, 1 odd parity |
| slip_n | input | 1 | Active-low slip strobe, asynchronous to clk |
| mode | input | 2 | 00 reserved, 01 half width, 10 full width, 11 all ones |
| word_out | output | 32 | Parallel word, first bit in bit 31 |
| par_out | output | 4 | Byte parity, bit 3 for byte 1 |
| word_clk | output | 1 | Divided word clock, falls when word_out loads |

## Verification
**Bit order and parity.** Single-bit words at each end of the word show whether the bit order is reversed. A walk of one set bit through every position shows any lane swap. A long stream of pseudo-random words, run with and without inversion and with both parity polarities, separates the even-parity case from the odd-parity case and shows which byte each parity bit covers.

**Slip.** Slip runs insert one extra bit that must vanish. One run has the strobe fall early in a word and stay low for more than a word. Another has it fall late in a word. Together they distinguish a correct single skip from these faults:
- no skip,
- a skip repeated while the strobe stays low,
- a skip at the wrong latency.

**Modes.** Half-width, all-ones and reserved modes are each run after a reset, to catch a wrong word length or a wrong mask on the unused lanes.

// File: rtl/sdx_pkg.sv
// Shared types for the serial demultiplexer.
// Assumes the mode code is static outside reset.
package sdx_pkg;
    typedef enum logic [1:0] {
        MD_RSVD = 2'b00,
        MD_HALF = 2'b01,
        MD_FULL = 2'b10,
        MD_ONES = 2'b11
    } sdx_mode_e;
endpackage

// File: rtl/sdx_slip_sync.sv
// Synchronizes the asynchronous active-low slip strobe into the bit clock
// domain and emits a one-cycle pulse per falling edge.
// Assumes the strobe stays at each level for at least two bit clocks.
module sdx_slip_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slip_n,
    output logic slip_pulse
);
    logic [STAGES:0] chain;

    // Shift the strobe through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-1:0], slip_n};
    end

    assign slip_pulse = chain[STAGES] & ~chain[STAGES-1];

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        slip_pulse |=> !slip_pulse);
endmodule

// File: rtl/sdx_phase_ctr.sv
// Bit-position counter within a word. Freezes for one cycle on hold,
// flags the loading cycle and the mid-word cycle.
// Assumes the half input changes only under reset.
module sdx_phase_ctr #(
    parameter int WIDTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic half,
    output logic word_end,
    output logic mid_point
);
    localparam int CW = $clog2(WIDTH);
    localparam logic [CW-1:0] FULL_LAST = CW'(WIDTH - 1);
    localparam logic [CW-1:0] HALF_LAST = CW'(WIDTH / 2 - 1);
    localparam logic [CW-1:0] FULL_MID  = CW'(WIDTH / 2 - 1);
    localparam logic [CW-1:0] HALF_MID  = CW'(WIDTH / 4 - 1);

    logic [CW-1:0] pos;
    logic [CW-1:0] last_pos;
    logic [CW-1:0] mid_pos;

    assign last_pos  = half ? HALF_LAST : FULL_LAST;
    assign mid_pos   = half ? HALF_MID  : FULL_MID;
    assign word_end  = !hold && (pos >= last_pos);
    assign mid_point = !hold && (pos == mid_pos);

    // Advance the position, wrap at word end, freeze on a slip.
    always_ff @(posedge clk) begin
        if (!rst_n)        pos <= '0;
        else if (hold)     pos <= pos;
        else if (word_end) pos <= '0;
        else               pos <= pos + 1'b1;
    end

    a_r6_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(pos));
    a_r10_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        word_end |=> (pos == '0));
endmodule

// File: rtl/sdx_shift_asm.sv
// Shift register that gathers serial bits, oldest toward the top.
// Holds only WIDTH-1 bits: the newest bit is merged by the consumer.
module sdx_shift_asm #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [WIDTH-2:0] history
);
    // Shift one bit in at the bottom whenever a bit is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)        history <= '0;
        else if (shift_en) history <= {history[WIDTH-3:0], bit_in};
    end
endmodule

// File: rtl/sdx_byte_parity.sv
// Per-byte parity generator; the top lane covers the most significant byte.
module sdx_byte_parity #(
    parameter int WIDTH = 32,
    parameter int LANE  = 8
) (
    input  logic [WIDTH-1:0]      word,
    input  logic                  odd,
    output logic [WIDTH/LANE-1:0] par
);
    localparam int NB = WIDTH / LANE;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign par[b] = (^word[b*LANE +: LANE]) ^ odd;
    end
endmodule

// File: rtl/serdemux_top.sv
// Serial to parallel demultiplexer with slip, inversion, mode select and
// byte parity. Loads the output register on the cycle the last bit of a
// word arrives; word_clk falls on that same edge.
// Assumes mode, invert and odd_par are static outside reset.
module serdemux_top #(
    parameter int WIDTH = 32,
    parameter int LANE  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ser_in,
    input  logic                  invert,
    input  logic                  odd_par,
    input  logic                  slip_n,
    input  logic [1:0]            mode,
    output logic [WIDTH-1:0]      word_out,
    output logic [WIDTH/LANE-1:0] par_out,
    output logic                  word_clk
);
    import sdx_pkg::*;

    localparam int NB   = WIDTH / LANE;
    localparam int HALF = WIDTH / 2;
    localparam int HNB  = NB / 2;
    localparam logic [NB-1:0] HALF_MASK = {{HNB{1'b1}}, {(NB-HNB){1'b0}}};

    sdx_mode_e md;
    logic      bit_v;
    logic      slip_pulse;
    logic      word_end;
    logic      mid_point;
    logic [WIDTH-2:0] history;
    logic [WIDTH-1:0] gathered;
    logic [WIDTH-1:0] next_word;
    logic [NB-1:0]    raw_par;
    logic [NB-1:0]    next_par;

    assign md    = sdx_mode_e'(mode);
    assign bit_v = ser_in ^ invert;

    sdx_slip_sync #(.STAGES(2)) u_slip (
        .clk(clk), .rst_n(rst_n), .slip_n(slip_n), .slip_pulse(slip_pulse)
    );

    sdx_phase_ctr #(.WIDTH(WIDTH)) u_ctr (
        .clk(clk), .rst_n(rst_n), .hold(slip_pulse), .half(md == MD_HALF),
        .word_end(word_end), .mid_point(mid_point)
    );

    sdx_shift_asm #(.WIDTH(WIDTH)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift_en(!slip_pulse), .bit_in(bit_v),
        .history(history)
    );

    assign gathered = {history, bit_v};

    // Select the word to load according to the mode code.
    always_comb begin
        unique case (md)
            MD_FULL: next_word = gathered;
            MD_HALF: next_word = {gathered[HALF-1:0], {HALF{1'b0}}};
            MD_ONES: next_word = '1;
            default: next_word = '0;
        endcase
    end

    sdx_byte_parity #(.WIDTH(WIDTH), .LANE(LANE)) u_par (
        .word(next_word), .odd(odd_par), .par(raw_par)
    );

    // Mask or force the parity lanes to match the mode.
    always_comb begin
        unique case (md)
            MD_FULL: next_par = raw_par;
            MD_HALF: next_par = raw_par & HALF_MASK;
            MD_ONES: next_par = '1;
            default: next_par = '0;
        endcase
    end

    // Output register and word clock, both timed by the word boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out <= '0;
            par_out  <= '0;
            word_clk <= 1'b1;
        end else if (word_end) begin
            word_out <= next_word;
            par_out  <= next_par;
            word_clk <= 1'b0;
        end else if (mid_point) begin
            word_clk <= 1'b1;
        end
    end

    a_r10_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !word_end |=> ($stable(word_out) && $stable(par_out)));
    a_r10_clk_falls: assert property (@(posedge clk) disable iff (!rst_n)
        word_end |=> !word_clk);
    a_r7_half_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (word_end && md == MD_HALF) |=> (word_out[HALF-1:0] == '0 && par_out[HNB-1:0] == '0));
    a_r8_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (word_end && md == MD_ONES) |=> (&word_out && &par_out));
    a_r9_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (word_end && md == MD_RSVD) |=> (word_out == '0 && par_out == '0));
    a_r3_even_top: assert property (@(posedge clk) disable iff (!rst_n)
        (word_end && md == MD_FULL && !odd_par) |=> !(^{word_out[WIDTH-1 -: LANE], par_out[NB-1]}));
    a_r4_odd_top: assert property (@(posedge clk) disable iff (!rst_n)
        (word_end && md == MD_FULL && odd_par) |=> (^{word_out[WIDTH-1 -: LANE], par_out[NB-1]}));
endmodule

// File: tb/serdemux_top_test.sv
module serdemux_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_in = 1'b0;
    logic        invert = 1'b0;
    logic        odd_par = 1'b0;
    logic        slip_n = 1'b1;
    logic [1:0]  mode = 2'b10;
    logic [31:0] word_out;
    logic [3:0]  par_out;
    logic        word_clk;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    serdemux_top uut (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .invert(invert),
        .odd_par(odd_par), .slip_n(slip_n), .mode(mode),
        .word_out(word_out), .par_out(par_out), .word_clk(word_clk)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] ref_par(input logic [31:0] w, input logic odd);
        logic [3:0] p;
        for (int b = 0; b < 4; b++) begin
            int ones = 0;
            for (int k = 0; k < 8; k++) ones += int'(w[b*8+k]);
            p[b] = logic'(ones % 2) ^ odd;
        end
        return p;
    endfunction

    task automatic do_reset(input logic [1:0] m);
        rst_n = 1'b0;
        mode  = m;
        slip_n = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    // Send len bits of w, starting at bit 31; check the mid-word clock rise.
    task automatic send_word(input logic [31:0] w, input int len, input logic [31:0] prev);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i == len / 2) begin
                check("R10 word_clk rises mid-word", 32'(word_clk), 32'd1);
                check("R10 word_out holds mid-word", word_out, prev);
            end
            ser_in = w[31-i];
        end
        @(posedge clk);
        #1;
    endtask

    // 33 bits: w with one extra bit inserted two steps after slip_n falls.
    task automatic send_slip_word(input logic [31:0] w, input int p, input logic extra);
        int j = 0;
        for (int s = 0; s < 33; s++) begin
            @(negedge clk);
            if (s == p) slip_n = 1'b0;
            if (s == p + 2) ser_in = extra;
            else begin
                ser_in = w[31-j];
                j++;
            end
        end
        @(posedge clk);
        #1;
    endtask

    task automatic check_full(input string req, input logic [31:0] sent);
        logic [31:0] e;
        e = invert ? ~sent : sent;
        check(req, word_out, e);
        check({req, " parity"}, 32'(par_out), 32'(ref_par(e, odd_par)));
        check("R10 word_clk low at load", 32'(word_clk), 32'd0);
    endtask

    initial begin
        logic [31:0] lfsr;
        logic [31:0] prev;
        do_reset(2'b10);
        check("R1 reset word", word_out, 32'd0);
        check("R1 reset parity", 32'(par_out), 32'd0);
        check("R1 reset word_clk", 32'(word_clk), 32'd1);

        // R1/R2: first bit goes to the MSB
        send_word(32'h8000_0000, 32, 32'd0);
        check_full("R1 R2 msb first", 32'h8000_0000);
        prev = word_out;
        send_word(32'h0000_0001, 32, prev);
        check_full("R2 lsb last", 32'h0000_0001);
        // R2: walking one
        for (int k = 0; k < 32; k++) begin
            prev = word_out;
            send_word(32'h1 << k, 32, prev);
            check_full("R2 walking one", 32'h1 << k);
        end
        // R3 R4 R5: pseudo-random sweep over parity and inversion
        lfsr = 32'hACE1_2468;
        for (int n = 0; n < 64; n++) begin
            odd_par = n[0];
            invert  = n[1];
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            prev = word_out;
            send_word(lfsr, 32, prev);
            if (invert) check_full("R5 inverted", lfsr);
            else if (odd_par) check_full("R4 odd parity", lfsr);
            else check_full("R3 even parity", lfsr);
        end
        odd_par = 1'b0;
        invert  = 1'b0;

        // R6: slip early in a word, held low across the whole word
        send_slip_word(32'h1234_5678, 3, ~1'b0);
        check_full("R6 slip early", 32'h1234_5678);
        slip_n = 1'b1;
        prev = word_out;
        send_word(32'hDEAD_BEEF, 32, prev);
        check_full("R6 no slip on rise or held low", 32'hDEAD_BEEF);
        send_slip_word(32'h0F0F_3C3C, 28, 1'b1);
        check_full("R6 slip late", 32'h0F0F_3C3C);
        slip_n = 1'b1;
        prev = word_out;
        send_word(32'hA5A5_5A5A, 32, prev);
        check_full("R6 aligned after slip", 32'hA5A5_5A5A);

        // R7: half-width mode
        do_reset(2'b01);
        for (int n = 0; n < 8; n++) begin
            logic [31:0] w;
            w = {16'(16'h9C31 * (n + 3)), 16'h0};
            odd_par = n[0];
            prev = word_out;
            send_word(w, 16, prev);
            check("R7 half word", word_out, w);
            check("R7 half parity", 32'(par_out), 32'(ref_par(w, odd_par) & 4'b1100));
            check("R7 word_clk low at load", 32'(word_clk), 32'd0);
        end
        odd_par = 1'b0;

        // R8: forced all ones
        do_reset(2'b11);
        send_word(32'h0000_0000, 32, 32'd0);
        check("R8 all ones word", word_out, 32'hFFFF_FFFF);
        check("R8 all ones parity", 32'(par_out), 32'hF);
        prev = word_out;
        send_word(32'h1357_9BDF, 32, prev);
        check("R8 all ones second word", word_out, 32'hFFFF_FFFF);

        // R9: reserved code
        do_reset(2'b00);
        send_word(32'hFFFF_FFFF, 32, 32'd0);
        check("R9 reserved word", word_out, 32'd0);
        check("R9 reserved parity", 32'(par_out), 32'd0);
        check("R9 word_clk low at load", 32'(word_clk), 32'd0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule